// File: doc/BRIEF.md
# Programmable 1-Wire Bit Sequencer

This block is the bit-level engine of a 1-Wire bus master. On a single command strobe it runs one of three operations on an open-drain line: a bus reset followed by a presence check, one write slot carrying a 0 or a 1, or one read slot that samples the level a slave leaves on the line. The length of every phase is set by its own timing input and counted in ticks of a divided timing clock. The sample points for the read bit and the presence response are also set separately.

The line input passes through a deglitch filter before any sample. The filter accepts a new level only after the level has stayed stable for six ticks. A bypass input shortens this to three ticks. Software or a higher-level sequencer provides the byte framing. It issues one command at a time, waits for the one-cycle done pulse, and then reads the returned bit or presence flag. These values stay held until the same kind of operation overwrites them. The block never drives the line high. It only asserts a drive-low request, and an external open-drain pad acts on it.

Top module: `owseq_top`

## Requirements
- R1: After reset, busy, done, lineDrvLow, rdBit and presence are all 0.
- R2: A reset operation (cmdOp = 0) holds lineDrvLow high for tRstl+1 ticks. It then releases the line for a recovery window of tRsth+1 ticks. A release gap of tRelease ticks follows, so busy lasts tRstl+tRsth+2+tRelease ticks.
- R3: During the recovery window, presence is loaded at recovery tick S = tPdh+1+min(tPsclk, tPdl-1). It is 1 when the filtered line is low at that point and 0 otherwise.
- R4: A write operation (cmdOp = 1) drives the line low for tLow0+1 ticks when cmdWrBit is 0, and for tLow1+1 ticks when it is 1. The slot lasts tSlot+1 ticks, and the tRelease gap follows it.
- R5: A read operation (cmdOp = 2) drives the line low for tLow1+1 ticks. rdBit takes the filtered line level seen at slot tick tRdsclk. The slot and the gap last as in R4.
- R6: The filter length K is 6, or 3 when bypassFilter is 1. A line level held for at least K ticks appears on the filtered level from K+1 ticks after it began. A level held for fewer than K ticks never appears there.
- R7: busy rises in the cycle after a command is accepted. done is a single-cycle pulse in the first cycle after busy falls.
- R8: A command strobe that arrives while busy is ignored. It neither extends the running operation nor starts another one.
- R9: rdBit changes only at a read sample and presence only at a presence sample. Each holds its value through operations of other kinds.
- R10: lineDrvLow is never asserted while the block is idle.
- R11: The command code 3 is a no-operation. It is not accepted, and busy and done stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 2 | Operation: 0 reset, 1 write, 2 read, 3 none |
| cmdWrBit | input | 1 | Bit value for a write slot |
| bypassFilter | input | 1 | Selects the 3-tick deglitch path |
| tRstl | input | CW | Reset low count, N+1 ticks |
| tRsth | input | CW | Recovery window count, N+1 ticks |
| tPdh | input | CW | Presence high wait, N+1 ticks |
| tPdl | input | CW | Presence window length, N ticks |
| tPsclk | input | CW | Presence sample offset into the window |
| tLow0 | input | CW | Write-0 low count, N+1 ticks |
| tLow1 | input | CW | Write-1 and read-start low count, N+1 ticks |
| tSlot | input | CW | Slot length, N+1 ticks |
| tRdsclk | input | CW | Read sample tick within the slot |
| tRelease | input | CW | Release gap after each operation, N ticks |
| lineIn | input | 1 | Sensed bus level |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdBit | output | 1 | Last sampled read bit |
| presence | output | 1 | Last presence result, 1 = device answered |
| lineDrvLow | output | 1 | Pull the bus low |

## Verification
The bench sweeps the read sample point across the whole early part of the slot for several start-pulse lengths and both filter paths. A design whose filter latency was off by one tick would return the stale low level one step too late or too early. A design that let short pulses through would read 0 where the bench expects 1. Presence is swept by moving the slave's response tick across the sample point, with an unclamped and a clamped offset. This catches a wrong offset sum or a missing window clamp. The bench also measures low and busy durations for write-0, write-1 and reset. It covers zero and non-zero release gaps, strobes injected mid-operation, the no-operation code, and the holding of results across operations of other kinds.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSTL,
    PH_RSTH,
    PH_SLOT,
    PH_GAP
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic useLow0;
    logic latchRd;
    logic latchPres;
  } strobe_t;

  // datapath -> control comparisons
  typedef struct packed {
    logic tick;
    logic endRstl;
    logic endRsth;
    logic endSlot;
    logic endGap;
    logic relZero;
    logic inLow;
    logic hitRd;
    logic hitPres;
  } flags_t;

endpackage

// File: rtl/owseq_deglitch.sv
module owseq_deglitch #(
  parameter int LONG  = 6,
  parameter int SHORT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic bypass,
  input  logic lineIn,
  output logic lineFilt
);

  logic [LONG-1:0] shReg;
  logic            filtQ;
  logic            longSame;
  logic            shortSame;

  // a window is "settled" when every tap agrees with the newest sample
  always_comb begin
    longSame  = 1'b1;
    shortSame = 1'b1;
    for (int i = 1; i < LONG; i++) begin
      if (shReg[i] != shReg[0]) begin
        longSame = 1'b0;
        if (i < SHORT) shortSame = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
      filtQ <= 1'b1;
    end else if (tick) begin
      shReg <= {shReg[LONG-2:0], lineIn};
      if (bypass ? shortSame : longSame) filtQ <= shReg[0];
    end
  end

  assign lineFilt = filtQ;

endmodule

// File: rtl/owseq_datapath.sv
module owseq_datapath
  import owseq_pkg::*;
#(
  parameter int CW  = 10,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic          bypassFilter,
  input  logic          lineIn,
  input  logic [CW-1:0] tRstl,
  input  logic [CW-1:0] tRsth,
  input  logic [CW-1:0] tPdh,
  input  logic [CW-1:0] tPdl,
  input  logic [CW-1:0] tPsclk,
  input  logic [CW-1:0] tLow0,
  input  logic [CW-1:0] tLow1,
  input  logic [CW-1:0] tSlot,
  input  logic [CW-1:0] tRdsclk,
  input  logic [CW-1:0] tRelease,
  output flags_t        fl,
  output logic          rdBit,
  output logic          presence
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          tick;
  logic [CW-1:0] cnt;
  logic          lineFilt;
  logic [CW:0]   presIdx;
  logic [CW-1:0] presOff;
  logic [CW-1:0] lowLim;
  logic          rdBitQ;
  logic          presQ;

  // timing-clock divider
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        divCnt <= '0;
        else if (divCnt == DW'(DIV - 1))  divCnt <= '0;
        else                              divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DW'(DIV - 1));
    end
  endgenerate

  // phase tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (st.cntClr) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  owseq_deglitch #(.LONG(6), .SHORT(3)) u_deglitch (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .bypass   (bypassFilter),
    .lineIn   (lineIn),
    .lineFilt (lineFilt)
  );

  // presence sample point, offset clamped into the presence window
  assign presOff = (tPsclk < tPdl) ? tPsclk : (tPdl - 1'b1);
  assign presIdx = {1'b0, tPdh} + (CW+1)'(1) + {1'b0, presOff};
  assign lowLim  = st.useLow0 ? tLow0 : tLow1;

  always_comb begin
    fl.tick    = tick;
    fl.endRstl = (cnt == tRstl);
    fl.endRsth = (cnt == tRsth);
    fl.endSlot = (cnt == tSlot);
    fl.endGap  = (cnt == (tRelease - 1'b1));
    fl.relZero = (tRelease == '0);
    fl.inLow   = (cnt <= lowLim);
    fl.hitRd   = (cnt == tRdsclk);
    fl.hitPres = ({1'b0, cnt} == presIdx);
  end

  // returned results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBitQ <= 1'b0;
      presQ  <= 1'b0;
    end else begin
      if (st.latchRd)   rdBitQ <= lineFilt;
      if (st.latchPres) presQ  <= ~lineFilt;
    end
  end

  assign rdBit    = rdBitQ;
  assign presence = presQ;

endmodule

// File: rtl/owseq_ctrl.sv
module owseq_ctrl
  import owseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdWrBit,
  input  flags_t     fl,
  output strobe_t    st,
  output logic       busy,
  output logic       done,
  output logic       lineDrvLow
);

  phase_e phase;
  op_e    opQ;
  logic   bitQ;
  logic   doneQ;
  logic   accept;
  logic   phaseEnd;
  logic   lastPhase;

  assign accept = (phase == PH_IDLE) && cmdValid && (op_e'(cmdOp) != OP_NONE);

  // a timed phase finishes on the tick where its count matches
  always_comb begin
    phaseEnd = 1'b0;
    unique case (phase)
      PH_RSTL: phaseEnd = fl.tick && fl.endRstl;
      PH_RSTH: phaseEnd = fl.tick && fl.endRsth;
      PH_SLOT: phaseEnd = fl.tick && fl.endSlot;
      PH_GAP:  phaseEnd = fl.tick && fl.endGap;
      default: phaseEnd = 1'b0;
    endcase
  end

  // operation ends straight after its main phase when there is no gap
  assign lastPhase = (phase == PH_GAP) ||
                     (((phase == PH_RSTH) || (phase == PH_SLOT)) && fl.relZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      opQ   <= OP_NONE;
      bitQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        opQ   <= op_e'(cmdOp);
        bitQ  <= cmdWrBit;
        phase <= (op_e'(cmdOp) == OP_RESET) ? PH_RSTL : PH_SLOT;
      end else if (phaseEnd) begin
        if (phase == PH_RSTL) begin
          phase <= PH_RSTH;
        end else if (lastPhase) begin
          phase <= PH_IDLE;
          doneQ <= 1'b1;
        end else begin
          phase <= PH_GAP;
        end
      end
    end
  end

  always_comb begin
    st.cntClr    = accept || phaseEnd;
    st.useLow0   = (opQ == OP_WRITE) && !bitQ;
    st.latchRd   = (phase == PH_SLOT) && (opQ == OP_READ) && fl.tick && fl.hitRd;
    st.latchPres = (phase == PH_RSTH) && fl.tick && fl.hitPres;
  end

  assign busy       = (phase != PH_IDLE);
  assign done       = doneQ;
  assign lineDrvLow = (phase == PH_RSTL) || ((phase == PH_SLOT) && fl.inLow);

endmodule

// File: rtl/owseq_top.sv
module owseq_top
  import owseq_pkg::*;
#(
  parameter int CW  = 10,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic          cmdWrBit,
  input  logic          bypassFilter,
  input  logic [CW-1:0] tRstl,
  input  logic [CW-1:0] tRsth,
  input  logic [CW-1:0] tPdh,
  input  logic [CW-1:0] tPdl,
  input  logic [CW-1:0] tPsclk,
  input  logic [CW-1:0] tLow0,
  input  logic [CW-1:0] tLow1,
  input  logic [CW-1:0] tSlot,
  input  logic [CW-1:0] tRdsclk,
  input  logic [CW-1:0] tRelease,
  input  logic          lineIn,
  output logic          busy,
  output logic          done,
  output logic          rdBit,
  output logic          presence,
  output logic          lineDrvLow
);

  strobe_t st;
  flags_t  fl;

  owseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdWrBit   (cmdWrBit),
    .fl         (fl),
    .st         (st),
    .busy       (busy),
    .done       (done),
    .lineDrvLow (lineDrvLow)
  );

  owseq_datapath #(.CW(CW), .DIV(DIV)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .bypassFilter (bypassFilter),
    .lineIn       (lineIn),
    .tRstl        (tRstl),
    .tRsth        (tRsth),
    .tPdh         (tPdh),
    .tPdl         (tPdl),
    .tPsclk       (tPsclk),
    .tLow0        (tLow0),
    .tLow1        (tLow1),
    .tSlot        (tSlot),
    .tRdsclk      (tRdsclk),
    .tRelease     (tRelease),
    .fl           (fl),
    .rdBit        (rdBit),
    .presence     (presence)
  );

endmodule

// File: rtl/owseq_checker.sv
module owseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       busy,
  input logic       done,
  input logic       rdBit,
  input logic       presence,
  input logic       lineDrvLow
);

  assert_idle_no_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineDrvLow);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // busy may only start from an idle-time strobe with a real opcode (R8, R11)
  assert_start_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cmdValid) && ($past(cmdOp) != 2'd3)));

  assert_rdbit_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdBit) |-> $past(busy));

  assert_presence_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(presence) |-> $past(busy));

endmodule

bind owseq_top owseq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .busy       (busy),
  .done       (done),
  .rdBit      (rdBit),
  .presence   (presence),
  .lineDrvLow (lineDrvLow)
);

// File: tb/owseq_top_test.sv
module owseq_top_test;

  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdOp = 2'd0;
  logic          cmdWrBit = 1'b0;
  logic          bypassFilter = 1'b0;
  logic [CW-1:0] tRstl, tRsth, tPdh, tPdl, tPsclk;
  logic [CW-1:0] tLow0, tLow1, tSlot, tRdsclk, tRelease;
  logic          lineIn;
  logic          busy, done, rdBit, presence, lineDrvLow;

  // slave model
  logic slaveAll = 1'b0;
  logic slaveDelayEn = 1'b0;
  int   slaveDelay = 0;
  int   relAge = 0;
  logic injectBusy = 1'b0;
  logic slaveLow;

  int nChecks = 0;
  int nFails  = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) relAge <= (busy && !lineDrvLow) ? relAge + 1 : 0;
  assign slaveLow = busy && (slaveAll || (slaveDelayEn && (relAge >= slaveDelay)));
  assign lineIn   = !(lineDrvLow || slaveLow);

  owseq_top #(.CW(CW), .DIV(1)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdWrBit(cmdWrBit), .bypassFilter(bypassFilter),
    .tRstl(tRstl), .tRsth(tRsth), .tPdh(tPdh), .tPdl(tPdl), .tPsclk(tPsclk),
    .tLow0(tLow0), .tLow1(tLow1), .tSlot(tSlot), .tRdsclk(tRdsclk),
    .tRelease(tRelease), .lineIn(lineIn), .busy(busy), .done(done),
    .rdBit(rdBit), .presence(presence), .lineDrvLow(lineDrvLow)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // issue one command and measure it at negedges
  task automatic runOp(input logic [1:0] op, input logic wb,
                       output int busyN, output int lowN, output int doneOk);
    int guard;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdWrBit = wb;
    @(negedge clk);
    cmdValid = 1'b0;
    busyN = 0; lowN = 0; guard = 0;
    while (busy && guard < 20000) begin
      busyN++;
      if (lineDrvLow) lowN++;
      if (injectBusy && busyN == 3) begin cmdValid = 1'b1; cmdOp = 2'd2; end
      else cmdValid = 1'b0;
      @(negedge clk);
      guard++;
    end
    cmdValid = 1'b0;
    doneOk = (done === 1'b1) ? 1 : 0;
    @(negedge clk);
    if (done !== 1'b0 || busy !== 1'b0) doneOk = 0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int bN, lN, dOk, k, s, expP, expR, keepR, keepP;
    tRstl = 10'h1DF; tRsth = 10'h1DF; tPdh = 10'h1E; tPdl = 10'h78; tPsclk = 10'h50;
    tLow0 = 10'd12; tLow1 = 10'd2; tSlot = 10'd20; tRdsclk = 10'd7; tRelease = 10'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 drive", lineDrvLow, 0);
    chk("R1 rdBit", rdBit, 0); chk("R1 presence", presence, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 typical reset timing, no slave
    runOp(2'd0, 1'b0, bN, lN, dOk);
    chk("R2 low", lN, 16'h1DF + 1);
    chk("R2 busy", bN, 16'h1DF * 2 + 2);
    chk("R3 absent", presence, 0);
    chk("R7 done", dOk, 1);
    slaveAll = 1'b1;
    runOp(2'd0, 1'b0, bN, lN, dOk);
    slaveAll = 1'b0;
    chk("R3 present", presence, 1);

    // R3/R6 presence sweep over slave response tick
    tRstl = 10'd8; tRsth = 10'd40; tPdh = 10'd9; tPdl = 10'd20; tRelease = 10'd3;
    for (int clamp = 0; clamp < 2; clamp++) begin
      tPsclk = clamp ? 10'd40 : 10'd12;
      s = 9 + 1 + (clamp ? 19 : 12);
      for (int bp = 0; bp < 2; bp++) begin
        bypassFilter = bp[0];
        k = bp ? 3 : 6;
        for (int d = s - k - 3; d <= s - k + 1; d++) begin
          slaveDelay = d; slaveDelayEn = 1'b1;
          runOp(2'd0, 1'b0, bN, lN, dOk);
          slaveDelayEn = 1'b0;
          expP = (s >= d + k + 1) ? 1 : 0;
          chk("R3 R6 presence sweep", presence, expP);
          chk("R2 busy small", bN, 8 + 40 + 2 + 3);
        end
      end
    end
    keepP = presence;

    // R4 write slots, R9 rdBit held
    keepR = rdBit;
    for (int rel = 0; rel < 2; rel++) begin
      tRelease = rel ? 10'd4 : 10'd0;
      for (int b = 0; b < 2; b++) begin
        runOp(2'd1, b[0], bN, lN, dOk);
        chk("R4 write low", lN, b ? 3 : 13);
        chk("R4 write busy", bN, 21 + (rel ? 4 : 0));
        chk("R7 write done", dOk, 1);
        chk("R9 rdBit held", rdBit, keepR);
      end
    end

    // R5/R6 read sweep over sample point, line released by slave
    tRelease = 10'd2;
    for (int bp = 0; bp < 2; bp++) begin
      bypassFilter = bp[0];
      k = bp ? 3 : 6;
      for (int t = 0; t < 4; t++) begin
        tLow1 = 10'(t);
        for (int r = 0; r <= t + k + 4; r++) begin
          tRdsclk = 10'(r);
          runOp(2'd2, 1'b0, bN, lN, dOk);
          if (t + 1 < k) expR = 1;
          else expR = (r >= k + 1 && r <= t + k + 1) ? 0 : 1;
          chk("R5 R6 read one", rdBit, expR);
          chk("R5 read low", lN, t + 1);
          chk("R5 read busy", bN, 21 + 2);
          slaveAll = 1'b1;
          runOp(2'd2, 1'b0, bN, lN, dOk);
          slaveAll = 1'b0;
          expR = (r >= k + 1) ? 0 : 1;
          chk("R5 R6 read zero", rdBit, expR);
          chk("R9 presence held", presence, keepP);
        end
      end
    end

    // R8 strobe during busy ignored
    tLow1 = 10'd2; tRelease = 10'd0;
    keepR = rdBit;
    injectBusy = 1'b1;
    runOp(2'd1, 1'b1, bN, lN, dOk);
    injectBusy = 1'b0;
    chk("R8 busy length", bN, 21);
    chk("R8 no second op", busy, 0);
    chk("R8 rdBit", rdBit, keepR);

    // R11 no-operation code
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd3;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R11 busy", busy, 0);
    @(negedge clk);
    chk("R11 done", done, 0);
    chk("R11 drive", lineDrvLow, 0);

    summary();
  end

endmodule